// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects sixteen external interrupt request lines and presents one interrupt output to a processor. Software gives every line a trigger mode of its own: it can follow the line while the line sits high or low, or it can record a rising or a falling transition. Every line also gets a priority level. The block synchronizes the lines into the clock domain and keeps a sticky flag for each edge event. It then picks one winner from the lines whose level is above a global threshold. The winner's index and level appear in a status word, and software clears a stored edge with an explicit command.

All configuration travels over a plain 32-bit word bus. A write happens on any clock edge that sees the write strobe high. Reads are combinational from the byte address. The processor reads the current-status word to learn which line it should service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, except the current-status word at 0xA0, which reads 0x0001_0000. `cpu_irq` is low. Addresses outside the map read 0.
- R2: Bit 0 of the word at 0x00 enables the controller and reads back; the other bits read 0. While this bit is 0 nothing is reported: the current status reads 0x0001_0000 and `cpu_irq` is low.
- R3: Each line has a 2-bit trigger code: 00 active low, 01 active high, 10 falling edge, 11 rising edge. Lines 0-7 are held in the word at 0x04 and lines 8-15 in the word at 0x08. Line n occupies bits [2*(n%8)+1 : 2*(n%8)]. Bits 31:16 of both words read 0.
- R4: Level word k sits at 0x10+4*k and holds line 2k in bits 7:0 and line 2k+1 in bits 15:8. Both bytes read back exactly as written. Only the low 3 bits of each byte set the level. Bits 31:16 read 0.
- R5: A line in a level mode (00 or 01) requests while its synchronized input matches the polarity. The request drops again when the input returns; nothing is stored.
- R6: A line in an edge mode (10 or 11) stores the selected transition of its synchronized input. The stored request stays active after the input goes back, until software clears it.
- R7: A write to 0x60 with bit 8 set clears the stored edge of the line whose index is in bits 3:0. A write with bit 8 clear changes nothing.
- R8: The threshold lives in bits 2:0 of the word at 0x40. A requesting line competes only if its level is strictly greater than the threshold, so level 0 never wins.
- R9: The competing line with the highest level wins. On a tie, the lowest index wins.
- R10: The current status at 0xA0 has three fields. Bit 16 is 0 while a winner exists and 1 otherwise. Bits 10:8 hold the winner's level and bits 4:0 its index. All other bits read 0, and both fields read 0 when there is no winner.
- R11: `cpu_irq` is high exactly when bit 16 of the current status reads 0.
- R12: The word at 0x80 shows the qualified request of every line in bits 15:0, whatever the levels, the threshold or the enable. Bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, one write per clock it is high |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_src | input | 16 | Asynchronous request lines |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The assertions assume two things about software. First, an edge clear is never issued in the same cycle as a new edge on the same line; if both happen, the edge wins and the line stays set. Second, a line's trigger mode is only changed while its input is steady. The stimulus keeps to both rules by letting every input change settle for several cycles before it writes a clear or a mode. It also sets each line's input to the inactive level before switching that line into an edge mode, so that no unintended transition gets recorded.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Trigger codes: bit 1 selects edge, bit 0 selects polarity.
  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_FALL = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;

  // Word addresses of the map.
  localparam logic [7:0] A_ENABLE   = 8'h00;
  localparam logic [7:0] A_MODE_BASE = 8'h04;
  localparam logic [7:0] A_LVL_BASE = 8'h10;
  localparam logic [7:0] A_MASK     = 8'h40;
  localparam logic [7:0] A_CLEAR    = 8'h60;
  localparam logic [7:0] A_SRCSTAT  = 8'h80;
  localparam logic [7:0] A_CURSTAT  = 8'hA0;

  // Field placement.
  localparam int unsigned CLR_GO_BIT   = 8;
  localparam int unsigned CUR_FLAG_BIT = 16;
  localparam int unsigned CUR_LVL_LSB  = 8;
  localparam int unsigned SRC_PER_MODE = 8;
  localparam int unsigned SRC_PER_LVL  = 2;
  localparam int unsigned LVL_BYTE_W   = 8;
  localparam int unsigned WORD_W       = 32;

endpackage

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(N_SRC),
  localparam int unsigned LAST       = SYNC_STAGES - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_i,
  input  logic [2*N_SRC-1:0] mode_i,
  input  logic               clr_go_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [N_SRC-1:0]   req_o,
  output logic [N_SRC-1:0]   evt_o,
  output logic [N_SRC-1:0]   latch_o
);

  logic [N_SRC-1:0] sync_q [SYNC_STAGES];
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] latch_q;
  logic [N_SRC-1:0] latch_nxt;
  logic [N_SRC-1:0] evt;
  logic [N_SRC-1:0] req;

  // Synchronizer chain, first stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= src_i;
  end

  // Remaining synchronizer stages.
  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[k] <= '0;
      else        sync_q[k] <= sync_q[k-1];
    end
  end

  // Edge detection, request qualification and sticky-flag next state.
  always_comb begin
    evt       = '0;
    req       = '0;
    latch_nxt = latch_q;
    for (int i = 0; i < N_SRC; i++) begin
      case (trig_e'(mode_i[2*i +: 2]))
        TRG_LOW:  req[i] = ~sync_q[LAST][i];
        TRG_HIGH: req[i] =  sync_q[LAST][i];
        TRG_FALL: begin
          evt[i] = ~sync_q[LAST][i] & prev_q[i];
          req[i] = latch_q[i];
        end
        default: begin
          evt[i] = sync_q[LAST][i] & ~prev_q[i];
          req[i] = latch_q[i];
        end
      endcase
      // A new edge beats a clear issued in the same cycle.
      latch_nxt[i] = evt[i] |
                     (latch_q[i] & ~(clr_go_i && (clr_idx_i == IDX_W'(i))));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_q[LAST];
      latch_q <= latch_nxt;
    end
  end

  assign req_o   = req;
  assign evt_o   = evt;
  assign latch_o = latch_q;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC   = 16,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W     = $clog2(N_SRC),
  localparam int unsigned MODE_REGS = N_SRC / SRC_PER_MODE,
  localparam int unsigned LVL_REGS  = N_SRC / SRC_PER_LVL,
  localparam int unsigned MODE_BITS = 2 * SRC_PER_MODE,
  localparam int unsigned LVL_BITS  = SRC_PER_LVL * LVL_BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [N_SRC-1:0]         req_i,
  input  logic [WORD_W-1:0]        cur_word_i,
  output logic                     en_o,
  output logic [2*N_SRC-1:0]       mode_o,
  output logic [N_SRC*LVL_W-1:0]   lvl_o,
  output logic [LVL_W-1:0]         mask_o,
  output logic                     clr_go_o,
  output logic [IDX_W-1:0]         clr_idx_o
);

  function automatic logic [ADDR_W-1:0] mode_addr(int j);
    return ADDR_W'(int'(A_MODE_BASE) + 4 * j);
  endfunction

  function automatic logic [ADDR_W-1:0] lvl_addr(int k);
    return ADDR_W'(int'(A_LVL_BASE) + 4 * k);
  endfunction

  logic                          en_q, en_nxt, en_we;
  logic [2*N_SRC-1:0]            mode_q, mode_nxt;
  logic                          mode_we;
  logic [N_SRC*LVL_BYTE_W-1:0]   lvlb_q, lvlb_nxt;
  logic                          lvl_we;
  logic [LVL_W-1:0]              mask_q, mask_nxt;
  logic                          mask_we;
  logic                          unused_wbits;

  assign unused_wbits = ^bus_wdata;

  // Write decode and next-state values.
  always_comb begin
    en_we    = bus_we && (bus_addr == ADDR_W'(A_ENABLE));
    en_nxt   = bus_wdata[0];
    mask_we  = bus_we && (bus_addr == ADDR_W'(A_MASK));
    mask_nxt = bus_wdata[LVL_W-1:0];
    mode_we  = 1'b0;
    mode_nxt = mode_q;
    for (int j = 0; j < MODE_REGS; j++) begin
      if (bus_we && (bus_addr == mode_addr(j))) begin
        mode_we = 1'b1;
        mode_nxt[j*MODE_BITS +: MODE_BITS] = bus_wdata[MODE_BITS-1:0];
      end
    end
    lvl_we   = 1'b0;
    lvlb_nxt = lvlb_q;
    for (int k = 0; k < LVL_REGS; k++) begin
      if (bus_we && (bus_addr == lvl_addr(k))) begin
        lvl_we = 1'b1;
        lvlb_nxt[k*LVL_BITS +: LVL_BITS] = bus_wdata[LVL_BITS-1:0];
      end
    end
  end

  // Registers with explicit clock enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      lvlb_q <= '0;
      mask_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_nxt;
      if (mode_we) mode_q <= mode_nxt;
      if (lvl_we)  lvlb_q <= lvlb_nxt;
      if (mask_we) mask_q <= mask_nxt;
    end
  end

  // Edge-clear command is a pulse on the write cycle.
  assign clr_go_o  = bus_we && (bus_addr == ADDR_W'(A_CLEAR)) && bus_wdata[CLR_GO_BIT];
  assign clr_idx_o = bus_wdata[IDX_W-1:0];

  // Effective levels: low bits of each byte.
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      lvl_o[i*LVL_W +: LVL_W] = lvlb_q[i*LVL_BYTE_W +: LVL_W];
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign mask_o = mask_q;

  // Read multiplexer.
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_ENABLE))  bus_rdata[0]          = en_q;
    if (bus_addr == ADDR_W'(A_MASK))    bus_rdata[LVL_W-1:0]  = mask_q;
    if (bus_addr == ADDR_W'(A_SRCSTAT)) bus_rdata[N_SRC-1:0]  = req_i;
    if (bus_addr == ADDR_W'(A_CURSTAT)) bus_rdata             = cur_word_i;
    for (int j = 0; j < MODE_REGS; j++) begin
      if (bus_addr == mode_addr(j))
        bus_rdata[MODE_BITS-1:0] = mode_q[j*MODE_BITS +: MODE_BITS];
    end
    for (int k = 0; k < LVL_REGS; k++) begin
      if (bus_addr == lvl_addr(k))
        bus_rdata[LVL_BITS-1:0] = lvlb_q[k*LVL_BITS +: LVL_BITS];
    end
  end

endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                   en_i,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]       mask_i,
  output logic                   win_vld_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [LVL_W-1:0]       win_lvl_o
);

  logic [LVL_W-1:0] lv;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    lv        = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      lv = lvl_i[i*LVL_W +: LVL_W];
      if (en_i && req_i[i] && (lv > mask_i) && (!win_vld_o || (lv >= win_lvl_o))) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lv;
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC       = 16,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  irq_src,
  output logic              cpu_irq
);

  logic [1:0]             rst_pipe_q;
  logic                   rst_s_n;
  logic                   en_w;
  logic [2*N_SRC-1:0]     mode_w;
  logic [N_SRC*LVL_W-1:0] lvl_w;
  logic [LVL_W-1:0]       mask_w;
  logic                   clr_go_w;
  logic [IDX_W-1:0]       clr_idx_w;
  logic [N_SRC-1:0]       req_w, evt_w, latch_w;
  logic                   win_vld;
  logic [IDX_W-1:0]       win_idx;
  logic [LVL_W-1:0]       win_lvl;
  logic                   cs_vld_q;
  logic [IDX_W-1:0]       cs_idx_q;
  logic [LVL_W-1:0]       cs_lvl_q;
  logic [WORD_W-1:0]      cur_word;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  irq_regs #(
    .N_SRC (N_SRC),
    .LVL_W (LVL_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_i     (req_w),
    .cur_word_i(cur_word),
    .en_o      (en_w),
    .mode_o    (mode_w),
    .lvl_o     (lvl_w),
    .mask_o    (mask_w),
    .clr_go_o  (clr_go_w),
    .clr_idx_o (clr_idx_w)
  );

  irq_front #(
    .N_SRC      (N_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .src_i    (irq_src),
    .mode_i   (mode_w),
    .clr_go_i (clr_go_w),
    .clr_idx_i(clr_idx_w),
    .req_o    (req_w),
    .evt_o    (evt_w),
    .latch_o  (latch_w)
  );

  irq_arb #(
    .N_SRC(N_SRC),
    .LVL_W(LVL_W)
  ) u_arb (
    .en_i     (en_w),
    .req_i    (req_w),
    .lvl_i    (lvl_w),
    .mask_i   (mask_w),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx),
    .win_lvl_o(win_lvl)
  );

  // Current-status register, refreshed every cycle.
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cs_vld_q <= 1'b0;
      cs_idx_q <= '0;
      cs_lvl_q <= '0;
    end else begin
      cs_vld_q <= win_vld;
      cs_idx_q <= win_idx;
      cs_lvl_q <= win_lvl;
    end
  end

  always_comb begin
    cur_word                         = '0;
    cur_word[CUR_FLAG_BIT]           = ~cs_vld_q;
    cur_word[CUR_LVL_LSB +: LVL_W]   = cs_lvl_q;
    cur_word[IDX_W-1:0]              = cs_idx_q;
  end

  assign cpu_irq = cs_vld_q;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [LVL_W-1:0]  mask,
  input logic              cpu_irq,
  input logic [WORD_W-1:0] cur_word,
  input logic [N_SRC-1:0]  req,
  input logic [N_SRC-1:0]  evt,
  input logic [N_SRC-1:0]  latch,
  input logic              clr_go,
  input logic [IDX_W-1:0]  clr_idx
);

  logic [LVL_W-1:0] cur_lvl;
  logic [IDX_W-1:0] cur_idx;
  assign cur_lvl = cur_word[CUR_LVL_LSB +: LVL_W];
  assign cur_idx = cur_word[IDX_W-1:0];

  // R2: a disabled controller reports nothing in the next cycle.
  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cpu_irq);

  // R8: the reported winner's level exceeds the threshold it was chosen under.
  a_r8_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (cur_lvl > $past(mask)));

  // R9: the reported winner was requesting when it was chosen.
  a_r9_winner_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((($past(req)) >> cur_idx) & N_SRC'(1)) != '0);

  // R10: with no winner, the flag is 1 and both fields read 0.
  a_r10_idle_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> (cur_word[CUR_FLAG_BIT] && (cur_lvl == '0) && (cur_idx == '0)));

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // R7: a clear without a competing edge empties the flag.
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_go && (clr_idx == IDX_W'(i)) && !evt[i]) |=> !latch[i]);
    // R6: a stored edge holds until its own clear.
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (latch[i] && !(clr_go && (clr_idx == IDX_W'(i)))) |=> latch[i]);
    // R5: without an edge event the flag never sets.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch[i] && !evt[i]) |=> !latch[i]);
  end

endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
  .N_SRC(N_SRC),
  .LVL_W(LVL_W)
) u_irq_chk (
  .clk     (clk),
  .rst_n   (rst_s_n),
  .en      (en_w),
  .mask    (mask_w),
  .cpu_irq (cpu_irq),
  .cur_word(cur_word),
  .req     (req_w),
  .evt     (evt_w),
  .latch   (latch_w),
  .clr_go  (clr_go_w),
  .clr_idx (clr_idx_w)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] irq_src;
  logic        cpu_irq;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .cpu_irq(cpu_irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Bench-side model of software-visible state.
  int         m_mode [N];
  logic [7:0] m_lvlb [N];
  int         m_mask;
  bit         m_en;
  bit         m_latch [N];

  function automatic int eff(int i);
    return int'(m_lvlb[i] & 8'h07);
  endfunction

  function automatic logic [15:0] exp_src();
    logic [15:0] q;
    for (int i = 0; i < N; i++) begin
      case (m_mode[i])
        0:       q[i] = !irq_src[i];
        1:       q[i] =  irq_src[i];
        default: q[i] =  m_latch[i];
      endcase
    end
    return q;
  endfunction

  function automatic logic [31:0] exp_cur();
    logic [15:0] q;
    int best;
    int bl;
    q = exp_src();
    best = -1;
    bl = 0;
    if (m_en) begin
      for (int i = 0; i < N; i++) begin
        if (q[i] && eff(i) > m_mask && eff(i) > bl) begin
          best = i;
          bl = eff(i);
        end
      end
    end
    if (best < 0) return 32'h0001_0000;
    return 32'((bl << 8) | best);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_state(string tag);
    logic [31:0] d;
    logic [31:0] e;
    rd(8'h80, d);
    chk({tag, " R12 srcstat"}, d, {16'b0, exp_src()});
    e = exp_cur();
    rd(8'hA0, d);
    chk({tag, " R10 curstat"}, d, e);
    chk({tag, " R11 cpu_irq"}, {31'b0, cpu_irq}, {31'b0, ~e[16]});
  endtask

  task automatic set_mode(int n, int md);
    logic [31:0] v;
    int base;
    m_mode[n] = md;
    base = (n / 8) * 8;
    v = '0;
    for (int s = 0; s < 8; s++) v |= 32'(m_mode[base + s]) << (2 * s);
    wr(8'(4 + 4 * (n / 8)), v);
  endtask

  task automatic set_lvl(int n, logic [7:0] b);
    int k;
    m_lvlb[n] = b;
    k = n / 2;
    wr(8'(16 + 4 * k), {16'b0, m_lvlb[2*k+1], m_lvlb[2*k]});
  endtask

  task automatic drive(logic [15:0] v);
    for (int i = 0; i < N; i++) begin
      if (m_mode[i] == 3 && !irq_src[i] && v[i]) m_latch[i] = 1;
      if (m_mode[i] == 2 && irq_src[i] && !v[i]) m_latch[i] = 1;
    end
    @(negedge clk);
    irq_src = v;
    settle();
  endtask

  task automatic clr(int idx, bit go);
    if (go) begin
      wr(8'h60, 32'h0000_0100 | 32'(idx));
      m_latch[idx] = 0;
    end else begin
      wr(8'h60, 32'hFFFF_FE00 | 32'(idx));
    end
    settle();
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] v;
    logic [15:0] pats [9];
    pats = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'h8001,
             16'h0F0F, 16'h1248, 16'h7FFE, 16'h0202};
    for (int i = 0; i < N; i++) begin
      m_mode[i] = 0; m_lvlb[i] = 8'h00; m_latch[i] = 0;
    end
    m_mask = 0; m_en = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_src = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1: reset values.
    rd(8'h00, d); chk("R1 enable", d, 32'h0);
    rd(8'h04, d); chk("R1 mode0", d, 32'h0);
    rd(8'h08, d); chk("R1 mode1", d, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rd(8'(16 + 4 * k), d); chk("R1 level", d, 32'h0);
    end
    rd(8'h40, d); chk("R1 mask", d, 32'h0);
    rd(8'hA0, d); chk("R1 curstat", d, 32'h0001_0000);
    rd(8'h0C, d); chk("R1 unmapped 0C", d, 32'h0);
    rd(8'h44, d); chk("R1 unmapped 44", d, 32'h0);
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
    check_state("R1");

    // R3 / R4 / R8 / R2 readback.
    wr(8'h04, 32'hFFFF_E4E4); rd(8'h04, d); chk("R3 mode0 readback", d, 32'h0000_E4E4);
    wr(8'h08, 32'h1234_1B1B); rd(8'h08, d); chk("R3 mode1 readback", d, 32'h0000_1B1B);
    wr(8'h04, 32'h0); wr(8'h08, 32'h0);
    wr(8'h14, 32'hABCD_F3FC); rd(8'h14, d); chk("R4 level readback", d, 32'h0000_F3FC);
    wr(8'h14, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R8 mask readback", d, 32'h7);
    wr(8'h40, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 enable readback", d, 32'h1);
    m_en = 1;
    settle();
    check_state("R2 enabled");

    // Per-line, per-mode sweep.
    for (int n = 0; n < N; n++) begin
      for (int md = 0; md < 4; md++) begin
        set_lvl(n, 8'hF8 | 8'((n % 7) + 1));
        v = irq_src;
        v[n] = (md % 2 == 0);
        drive(v);
        set_mode(n, md);
        settle();
        check_state("R3 idle");
        v[n] = ~v[n];
        drive(v);
        check_state(md >= 2 ? "R6 edge seen" : "R5 level on");
        v[n] = ~v[n];
        drive(v);
        check_state(md >= 2 ? "R6 edge held" : "R5 level off");
        if (md >= 2) begin
          clr(n, 0);
          check_state("R7 no-go write");
          clr(n, 1);
          check_state("R7 clear");
        end
        set_mode(n, 0);
        set_lvl(n, 8'h00);
      end
    end

    // Arbitration and threshold sweep with active-high lines.
    for (int i = 0; i < N; i++) m_mode[i] = 1;
    wr(8'h04, 32'h5555); wr(8'h08, 32'h5555);
    for (int i = 0; i < N; i++) set_lvl(i, 8'((i * 5 + 3) % 8) | 8'(i << 4));
    for (int mk = 0; mk < 8; mk++) begin
      m_mask = mk;
      wr(8'h40, 32'(mk));
      for (int p = 0; p < 9; p++) begin
        drive(pats[p]);
        check_state("R9 R8 arbitration");
      end
    end

    // R2: disable with requests present.
    m_mask = 0; wr(8'h40, 32'h0);
    drive(16'hFFFF);
    check_state("R9 tie");
    wr(8'h00, 32'h0); m_en = 0; settle();
    check_state("R2 disabled");
    wr(8'h00, 32'h1); m_en = 1; settle();
    check_state("R2 re-enabled");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule